// File: doc/BRIEF.md
# Paged Memory Map Decoder

This block sits on the external bus of an 8-bit microcontroller and turns each bus cycle into memory and peripheral selects. Code accesses go to a 128K main flash built from eight 16K segments. Three 64K code pages share a common lower 32K, and a small page register chooses which flash segments fill the upper 32K. After reset, a protected 32K boot area covers the lower half of code space. A one-cycle `go_pulse` removes that overlay, and from then on user flash is seen from address 0000h.

Data accesses are sorted into three kinds of target. The non-volatile RAM answers at 0000h–7FFFh, a scratchpad RAM at 8000h–87FFh, and the configuration register page at C000h–C0FFh. Seven 256-byte peripheral windows start at 8800h. Each window drives its own pin with its own polarity, and each pin is active only while a read or write strobe is low. A data write to C0E0h changes the two low bits of the page register and leaves its upper bits alone. A data read of C0E0h returns the whole register on `page_rdata`.

The control path is a two-state machine. `ST_BOOT` is the state on reset, and the overlay is active in it. `ST_USER` is the state with the overlay released. There is one transition, `ST_BOOT -> ST_USER`, taken on `go_pulse`. Only reset returns the machine to `ST_BOOT`. The page register is updated in the same process clock as the state machine.

Top module: `paged_map_decoder`

## Requirements
- R1: During and after reset the machine is in `ST_BOOT` and the page register holds 8'hB0: reserved bits [7:2] = 6'b101100 and page bits [1:0] = 0.
- R2: In `ST_BOOT`, a code access below 8000h gives `boot_sel`=1, `boot_seg`=addr[14:13], `seg_off`={1'b0, addr[12:0]}, and `flash_sel`=0.
- R3: `go_pulse` moves the machine from `ST_BOOT` to `ST_USER` in the next cycle. In `ST_USER`, `go_pulse` has no effect, and only reset leaves that state.
- R4: A code access below 8000h that the overlay does not cover gives `flash_sel`=1 and `flash_seg`=addr[15:14] (segment 0 or 1), whatever the page.
- R5: A code access at or above 8000h gives `flash_sel`=1 and `seg_off`=addr[13:0]. The segment depends on the page. Page 0 gives {2'b01, addr[14]} (segment 2 or 3). Page 1 gives {2'b10, addr[14]} (segment 4 or 5). Page 2 gives {2'b11, addr[14]} (segment 6 or 7). Page value 3 maps like page 0. The overlay never covers this half.
- R6: A data write to C0E0h loads `page_wdata` into page bits [1:0] at the next cycle and leaves bits [7:2] unchanged. A data read of C0E0h shows the register on `page_rdata` in the same cycle. At all other times `page_rdata` is 0.
- R7: A data access selects the non-volatile RAM (`nvram_sel`) at 0000h–7FFFh, the scratchpad (`scratch_sel`) at 8000h–87FFh, and the configuration page (`cfg_sel`) at C000h–C0FFh.
- R8: `periph_pin[0]`, `periph_pin[1]` and `periph_pin[2]` are active low. Each is driven low during a data access to 8800h–88FFh, 8900h–89FFh and 8A00h–8AFFh respectively.
- R9: `periph_pin[3]` (8B00h window) and `periph_pin[4]` (8C00h window) are active high. `periph_pin[5]` (8D00h window) and `periph_pin[6]` (8E00h window) are active low. With no read or write strobe low, every pin rests at its inactive level, which is 7'b1100111.
- R10: A data access to an unmapped address (8F00h–BFFFh, C100h–FFFFh) asserts no select. A code access asserts no data-space select.
- R11: With `code_space`=1, a read or write strobe addresses code space and follows R2, R4 and R5. A low `psen_n` always means a code access.
- R12: A page write and `go_pulse` in the same cycle both take effect at the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| page_wdata | input | 2 | Low two data-bus bits, used for a page write |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| psen_n | input | 1 | Program-store strobe, active low |
| code_space | input | 1 | 1: read/write strobes address code space |
| go_pulse | input | 1 | Releases the boot overlay |
| flash_sel | output | 1 | Main flash selected |
| flash_seg | output | 3 | Main flash segment 0–7 |
| seg_off | output | 14 | Offset inside the selected segment |
| boot_sel | output | 1 | Boot area selected |
| boot_seg | output | 2 | Boot segment 0–3 |
| nvram_sel | output | 1 | Non-volatile RAM selected |
| scratch_sel | output | 1 | Scratchpad RAM selected |
| cfg_sel | output | 1 | Configuration page selected |
| periph_pin | output | 7 | Peripheral select pins, mixed polarity |
| page_rdata | output | 8 | Page register read data |

## Verification
Two functions can fall in the same cycle: the page write and the overlay release. The bench drives a data write to C0E0h and `go_pulse` in a single cycle while the machine is still in `ST_BOOT`. In the next cycle it checks a low-half fetch, which must now reach user flash, and an upper-half fetch, which must use the new page. A long randomised run then mixes strobes, pages, go pulses and addresses. In every cycle all outputs are compared with a behavioural model in the bench.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    // Overlay state machine encoding
    typedef enum logic [0:0] {
        ST_BOOT = 1'b0,
        ST_USER = 1'b1
    } ovl_state_e;

    // Fixed bus geometry
    localparam int BUS_AW     = 16;
    localparam int SEG_OFF_W  = BUS_AW - 2;   // 16K segment
    localparam int FSEG_W     = 3;            // eight main segments
    localparam int BSEG_W     = 2;            // four boot segments

endpackage

// File: rtl/mmd_ctrl.sv
module mmd_ctrl
    import mmd_pkg::*;
#(
    parameter int                      REG_W     = 8,
    parameter int                      PAGE_W    = 2,
    parameter logic [REG_W-PAGE_W-1:0] RSVD_INIT = 6'b101100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_pulse,
    input  logic             wr_hit,
    input  logic [PAGE_W-1:0] wr_page,
    output logic             overlay,
    output logic [REG_W-1:0] page_q
);

    localparam logic [REG_W-1:0] PAGE_RESET = {RSVD_INIT, {PAGE_W{1'b0}}};

    ovl_state_e state_q, state_d;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (go_pulse) state_d = ST_USER;
            ST_USER: state_d = ST_USER;
        endcase
    end

    // State register and page register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            page_q  <= PAGE_RESET;
        end else begin
            state_q <= state_d;
            if (wr_hit) begin
                page_q[PAGE_W-1:0] <= wr_page;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_BOOT: overlay = 1'b1;
            ST_USER: overlay = 1'b0;
        endcase
    end

    AST_USER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_USER) |=> (state_q == ST_USER)); // R3
    AST_GO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |=> !overlay); // R3
    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(page_q[REG_W-1:PAGE_W])); // R6
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(page_q)); // R6
    AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (page_q[PAGE_W-1:0] == $past(wr_page))); // R12

endmodule

// File: rtl/mmd_code_dec.sv
module mmd_code_dec
    import mmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BUS_AW-1:0]    addr,
    input  logic                 code_acc,
    input  logic                 overlay,
    input  logic [1:0]           page,
    output logic                 flash_sel,
    output logic [FSEG_W-1:0]    flash_seg,
    output logic [SEG_OFF_W-1:0] seg_off,
    output logic                 boot_sel,
    output logic [BSEG_W-1:0]    boot_seg
);

    localparam int TOP = BUS_AW - 1;   // half select bit
    localparam int SUB = BUS_AW - 2;   // segment within half

    // Segment of the upper code half for a given page
    function automatic logic [FSEG_W-1:0] upper_seg(input logic [1:0] pg, input logic sub);
        unique case (pg)
            2'd1:    upper_seg = {2'b10, sub};
            2'd2:    upper_seg = {2'b11, sub};
            default: upper_seg = {2'b01, sub};
        endcase
    endfunction

    logic upper_half;
    assign upper_half = addr[TOP];

    always_comb begin
        flash_sel = 1'b0;
        flash_seg = '0;
        seg_off   = '0;
        boot_sel  = 1'b0;
        boot_seg  = '0;
        if (code_acc) begin
            if (overlay && !upper_half) begin
                boot_sel = 1'b1;
                boot_seg = addr[SUB:SUB-1];
                seg_off  = {1'b0, addr[SUB-2:0]};
            end else begin
                flash_sel = 1'b1;
                seg_off   = addr[SEG_OFF_W-1:0];
                if (upper_half) begin
                    flash_seg = upper_seg(page, addr[SUB]);
                end else begin
                    flash_seg = {1'b0, addr[TOP:SUB]};
                end
            end
        end
    end

    AST_BOOT_FLASH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(boot_sel && flash_sel)); // R2
    AST_COMMON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_sel && !addr[TOP]) |-> (flash_seg[FSEG_W-1] == 1'b0)); // R4
    AST_UPPER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (code_acc && addr[TOP]) |-> (flash_sel && flash_seg >= 3'd2)); // R5

endmodule

// File: rtl/mmd_data_dec.sv
module mmd_data_dec
    import mmd_pkg::*;
#(
    parameter int                    NUM_PERIPH  = 7,
    parameter logic [NUM_PERIPH-1:0] PERIPH_POL  = 7'b0011000,
    parameter logic [7:0]            PERIPH_BASE = 8'h88,
    parameter logic [7:0]            CFG_PAGE    = 8'hC0,
    parameter logic [BUS_AW-1:0]     SCRATCH_END = 16'h87FF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BUS_AW-1:0]     addr,
    input  logic                  data_acc,
    output logic                  nvram_sel,
    output logic                  scratch_sel,
    output logic                  cfg_sel,
    output logic [NUM_PERIPH-1:0] periph_pin
);

    localparam logic [BUS_AW-1:0] SCRATCH_START = {1'b1, {(BUS_AW-1){1'b0}}};

    logic [7:0]            hi_byte;
    logic [NUM_PERIPH-1:0] periph_hit;

    assign hi_byte = addr[BUS_AW-1:BUS_AW-8];

    always_comb begin
        nvram_sel   = data_acc && !addr[BUS_AW-1];
        scratch_sel = data_acc && (addr >= SCRATCH_START) && (addr <= SCRATCH_END);
        cfg_sel     = data_acc && (hi_byte == CFG_PAGE);
    end

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_win
        localparam logic [7:0] WIN = PERIPH_BASE + 8'(i);
        assign periph_hit[i] = data_acc && (hi_byte == WIN);
        if (PERIPH_POL[i]) begin : g_high
            assign periph_pin[i] = periph_hit[i];
        end else begin : g_low
            assign periph_pin[i] = !periph_hit[i];
        end
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nvram_sel, scratch_sel, cfg_sel, (periph_pin ^ ~PERIPH_POL)})); // R10
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !data_acc |-> (periph_pin == ~PERIPH_POL)); // R9
    AST_IDLE_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        !data_acc |-> !(nvram_sel || scratch_sel || cfg_sel)); // R10

endmodule

// File: rtl/paged_map_decoder.sv
module paged_map_decoder
    import mmd_pkg::*;
#(
    parameter int                      NUM_PERIPH  = 7,
    parameter logic [NUM_PERIPH-1:0]   PERIPH_POL  = 7'b0011000,
    parameter logic [7:0]              PERIPH_BASE = 8'h88,
    parameter logic [7:0]              CFG_PAGE    = 8'hC0,
    parameter logic [15:0]             PAGE_ADDR   = 16'hC0E0,
    parameter logic [15:0]             SCRATCH_END = 16'h87FF,
    parameter int                      REG_W       = 8,
    parameter int                      PAGE_W      = 2,
    parameter logic [REG_W-PAGE_W-1:0] RSVD_INIT   = 6'b101100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           bus_addr,
    input  logic [PAGE_W-1:0]     page_wdata,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic                  psen_n,
    input  logic                  code_space,
    input  logic                  go_pulse,
    output logic                  flash_sel,
    output logic [2:0]            flash_seg,
    output logic [13:0]           seg_off,
    output logic                  boot_sel,
    output logic [1:0]            boot_seg,
    output logic                  nvram_sel,
    output logic                  scratch_sel,
    output logic                  cfg_sel,
    output logic [NUM_PERIPH-1:0] periph_pin,
    output logic [REG_W-1:0]      page_rdata
);

    logic             strobe;
    logic             code_acc;
    logic             data_acc;
    logic             wr_hit;
    logic             rd_hit;
    logic             overlay;
    logic [REG_W-1:0] page_q;

    // Bus cycle classification
    always_comb begin
        strobe   = !rd_n || !wr_n;
        code_acc = !psen_n || (code_space && strobe);
        data_acc = psen_n && !code_space && strobe;
        wr_hit   = data_acc && !wr_n && (bus_addr == PAGE_ADDR);
        rd_hit   = data_acc && !rd_n && (bus_addr == PAGE_ADDR);
    end

    assign page_rdata = rd_hit ? page_q : '0;

    mmd_ctrl #(
        .REG_W     (REG_W),
        .PAGE_W    (PAGE_W),
        .RSVD_INIT (RSVD_INIT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_pulse (go_pulse),
        .wr_hit   (wr_hit),
        .wr_page  (page_wdata),
        .overlay  (overlay),
        .page_q   (page_q)
    );

    mmd_code_dec u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .code_acc  (code_acc),
        .overlay   (overlay),
        .page      (page_q[1:0]),
        .flash_sel (flash_sel),
        .flash_seg (flash_seg),
        .seg_off   (seg_off),
        .boot_sel  (boot_sel),
        .boot_seg  (boot_seg)
    );

    mmd_data_dec #(
        .NUM_PERIPH  (NUM_PERIPH),
        .PERIPH_POL  (PERIPH_POL),
        .PERIPH_BASE (PERIPH_BASE),
        .CFG_PAGE    (CFG_PAGE),
        .SCRATCH_END (SCRATCH_END)
    ) u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (bus_addr),
        .data_acc    (data_acc),
        .nvram_sel   (nvram_sel),
        .scratch_sel (scratch_sel),
        .cfg_sel     (cfg_sel),
        .periph_pin  (periph_pin)
    );

    AST_CODE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> (!nvram_sel && !scratch_sel && !cfg_sel)); // R11
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (page_rdata == '0)); // R6

endmodule

// File: tb/tb_paged_map_decoder.sv
module tb_paged_map_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [1:0]  page_wdata = 2'b0;
    logic        rd_n = 1'b1, wr_n = 1'b1, psen_n = 1'b1;
    logic        code_space = 1'b0, go_pulse = 1'b0;
    logic        flash_sel, boot_sel, nvram_sel, scratch_sel, cfg_sel;
    logic [2:0]  flash_seg;
    logic [13:0] seg_off;
    logic [1:0]  boot_seg;
    logic [6:0]  periph_pin;
    logic [7:0]  page_rdata;

    int total = 0;
    int bad   = 0;

    // Behavioural reference state
    bit       m_overlay = 1'b1;
    bit [7:0] m_page    = 8'hB0;

    always #10 clk = ~clk;

    paged_map_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .page_wdata(page_wdata),
        .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n), .code_space(code_space),
        .go_pulse(go_pulse), .flash_sel(flash_sel), .flash_seg(flash_seg),
        .seg_off(seg_off), .boot_sel(boot_sel), .boot_seg(boot_seg),
        .nvram_sel(nvram_sel), .scratch_sel(scratch_sel), .cfg_sel(cfg_sel),
        .periph_pin(periph_pin), .page_rdata(page_rdata)
    );

    function automatic logic [38:0] expect_out();
        logic [38:0] e;
        bit code, data, fl, bt, nv, sc, cf;
        int seg, bseg, off, pg, a;
        logic [6:0] pins;
        logic [7:0] rdv;
        a    = int'(bus_addr);
        code = !psen_n || (code_space && (!rd_n || !wr_n));
        data = psen_n && !code_space && (!rd_n || !wr_n);
        fl = 0; bt = 0; seg = 0; bseg = 0; off = 0;
        if (code) begin
            if (m_overlay && a < 32768) begin
                bt = 1; bseg = a / 8192; off = a % 8192;
            end else begin
                fl = 1; off = a % 16384;
                pg = int'(m_page[1:0]);
                if (a < 32768)      seg = a / 16384;
                else if (pg == 1)   seg = 4 + (a / 16384) % 2;
                else if (pg == 2)   seg = 6 + (a / 16384) % 2;
                else                seg = 2 + (a / 16384) % 2;
            end
        end
        nv = data && a < 32768;
        sc = data && a >= 32768 && a <= 34815;
        cf = data && (a / 256) == 192;
        for (int i = 0; i < 7; i++) begin
            bit hit, hi;
            hit = data && (a / 256) == (136 + i);
            hi  = (i == 3 || i == 4);
            pins[i] = hi ? hit : !hit;
        end
        rdv = (data && !rd_n && a == 49376) ? m_page : 8'h00;
        e = {fl, 3'(seg), 14'(off), bt, 2'(bseg), nv, sc, cf, pins, rdv};
        return e;
    endfunction

    task automatic check_now(input string tag);
        logic [38:0] act, exp;
        act = {flash_sel, flash_seg, seg_off, boot_sel, boot_seg,
               nvram_sel, scratch_sel, cfg_sel, periph_pin, page_rdata};
        exp = expect_out();
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, bus_addr, act, exp);
        end
    endtask

    // kind: 0 idle, 1 psen fetch, 2 data read, 3 data write, 4 code-space read, 5 code-space write
    task automatic step(input logic [15:0] a, input int kind, input bit g,
                        input logic [1:0] d, input string tag);
        @(negedge clk);
        bus_addr   = a;
        page_wdata = d;
        go_pulse   = g;
        psen_n     = !(kind == 1);
        rd_n       = !(kind == 2 || kind == 4);
        wr_n       = !(kind == 3 || kind == 5);
        code_space = (kind == 4 || kind == 5);
        #4;
        check_now(tag);
        @(posedge clk);
        if (rst_n) begin
            if (psen_n && !code_space && !wr_n && bus_addr == 16'hC0E0)
                m_page[1:0] = page_wdata;
            if (go_pulse) m_overlay = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        psen_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; go_pulse = 1'b0; code_space = 1'b0;
        m_overlay = 1'b1;
        m_page    = 8'hB0;
        #4;
        check_now("R1");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #4_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state observed through the ports
        step(16'h0000, 0, 0, 2'd0, "R1");
        step(16'h0000, 1, 0, 2'd0, "R1");
        step(16'hC0E0, 2, 0, 2'd0, "R1");
        // R2: boot overlay
        step(16'h5ABC, 1, 0, 2'd0, "R2");
        step(16'h7FFF, 1, 0, 2'd0, "R2");
        // R5: upper half not overlaid, page 0
        step(16'h9234, 1, 0, 2'd0, "R5");
        // R6: page write keeps reserved bits
        step(16'hC0E0, 3, 0, 2'd3, "R6");
        step(16'hC0E0, 2, 0, 2'd0, "R6");
        step(16'hC000, 1, 0, 2'd0, "R5");
        step(16'hC0E0, 3, 0, 2'd1, "R6");
        step(16'h8000, 1, 0, 2'd0, "R5");
        step(16'hC123, 1, 0, 2'd0, "R5");
        // R3: release overlay
        step(16'h1000, 1, 1, 2'd0, "R3");
        step(16'h1000, 1, 0, 2'd0, "R3");
        step(16'h4000, 1, 1, 2'd0, "R4");
        step(16'h2000, 1, 0, 2'd0, "R3");
        step(16'h3FFF, 1, 0, 2'd0, "R4");
        // R12: write and go in the same cycle
        do_reset();
        step(16'hC0E0, 3, 1, 2'd2, "R12");
        step(16'h0000, 1, 0, 2'd0, "R12");
        step(16'hE000, 1, 0, 2'd0, "R12");
        step(16'hC0E0, 2, 0, 2'd0, "R12");
        // R7: data targets
        step(16'h0000, 2, 0, 2'd0, "R7");
        step(16'h7FFF, 3, 0, 2'd0, "R7");
        step(16'h8000, 2, 0, 2'd0, "R7");
        step(16'h87FF, 3, 0, 2'd0, "R7");
        step(16'hC0FF, 2, 0, 2'd0, "R7");
        // R8: active-low windows
        step(16'h8800, 2, 0, 2'd0, "R8");
        step(16'h89FF, 3, 0, 2'd0, "R8");
        step(16'h8A10, 2, 0, 2'd0, "R8");
        // R9: mixed polarity and strobe qualification
        step(16'h8B00, 2, 0, 2'd0, "R9");
        step(16'h8C55, 3, 0, 2'd0, "R9");
        step(16'h8D00, 2, 0, 2'd0, "R9");
        step(16'h8EFF, 3, 0, 2'd0, "R9");
        step(16'h8B00, 0, 0, 2'd0, "R9");
        step(16'h8800, 0, 0, 2'd0, "R9");
        // R10: unmapped data and code accesses
        step(16'h8F00, 2, 0, 2'd0, "R10");
        step(16'hBFFF, 3, 0, 2'd0, "R10");
        step(16'hC100, 2, 0, 2'd0, "R10");
        step(16'hFFFF, 3, 0, 2'd0, "R10");
        step(16'h8800, 1, 0, 2'd0, "R10");
        // R11: code space through read and write strobes
        step(16'h9000, 4, 0, 2'd0, "R11");
        step(16'hC0E0, 5, 0, 2'd1, "R11");
        step(16'hC0E0, 2, 0, 2'd0, "R11");
        step(16'h0123, 4, 0, 2'd0, "R11");
        // Randomised run against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            int sel, kind;
            bit g;
            sel = int'($urandom % 8);
            case (sel)
                0: a = 16'($urandom % 32768);
                1: a = 16'h8000 + 16'($urandom % 2048);
                2: a = {8'h88 + 8'($urandom % 7), 8'($urandom)};
                3: a = 16'h8F00 + 16'($urandom % 12544);
                4: a = 16'hC0E0;
                5: a = {8'hC0, 8'($urandom)};
                default: a = 16'($urandom);
            endcase
            kind = int'($urandom % 6);
            g    = ($urandom % 40) == 0;
            if (n % 700 == 699) do_reset();
            step(a, kind, g, 2'($urandom), "R5");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule